// File: doc/BRIEF.md
# Replaying Flit Input Buffer

This block is one input buffer of an on-chip router, together with the path a flit takes from that buffer through the switch to an output channel. Flits arrive on the input side and are stored in a circular buffer. They are read out when the external arbiter grants this buffer. They then pass through a fixed-latency switch pipeline and reach a CRC checker on the output channel. Only flits whose recomputed CRC matches the CRC they carry are delivered downstream.

Three pointers track the buffer. The tail marks where the next arriving flit is written. The head marks the next flit to route. The recovery pointer marks the oldest flit that has been read but not yet confirmed at the output. A flit stays in the buffer until it passes its output check, so a detected error can be undone. The error can come from this channel's own checker or from any other channel in the router. In either case, outgoing flits are discarded, the pipeline is emptied, and the head is moved back to the recovery pointer. Routing then replays from the first unconfirmed flit.

Top module: `flit_replay_buf`

## Requirements
- R1: A flit is DATA_W payload bits in its upper field and an 8-bit CRC in bits [7:0]. The CRC is CRC-8 with polynomial 0x07 and an initial value of zero, taken over the payload most significant bit first. A flit whose recomputed CRC matches its CRC field appears on `out_data_o` as its payload, with `out_vld_o` high for one cycle.
- R2: Take an idle, empty buffer with `grant_i` held high. A flit written on rising edge W shows `out_vld_o` high after edge W+PIPE_LAT+1, and low after the edges before it.
- R3: Every accepted flit is delivered exactly once and in arrival order, including when routing is replayed after an error.
- R4: `in_rdy_o` is low when tail minus recovery pointer equals DEPTH. A flit that is unconfirmed is never overwritten.
- R5: While `grant_i` is low, no flit is read and `out_vld_o` stays low.
- R6: A flit that fails its output CRC check is not delivered. `err_o` goes high for exactly one cycle, after the edge on which that flit is checked.
- R7: A high `peer_err_i`, which is the error signal from another output channel, starts the same recovery as a local CRC error.
- R8: Writes, reads and deliveries are all held off in three cycles: the cycle in which an error is seen, the flush cycle that follows it, and the rewind cycle after that. `in_rdy_o` is low in all three cycles and is free again in the fourth.
- R9: At the end of recovery the head pointer equals the recovery pointer. Delivery resumes with the oldest unconfirmed flit.
- R10: The recovery pointer advances by exactly one entry for each flit that passes its output check, and at no other time. A flit that has been read but not confirmed keeps its buffer entry occupied.
- R11: After reset, `in_rdy_o` is high and `out_vld_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | An incoming flit is present |
| in_flit_i | input | FLIT_W | Incoming flit: payload above, CRC in [7:0] |
| in_rdy_o | output | 1 | The buffer accepts a flit this cycle |
| grant_i | input | 1 | The arbiter grants this buffer a read |
| fault_mask_i | input | FLIT_W | XOR fault-injection mask on the switch output path |
| peer_err_i | input | 1 | An error detected on another output channel |
| out_vld_o | output | 1 | A checked flit is delivered |
| out_data_o | output | DATA_W | Payload of the delivered flit |
| err_o | output | 1 | One-cycle pulse when the local CRC check fails |

## Verification
The bound checker covers the pointer rules on every cycle:
- the tail never runs more than DEPTH entries past the recovery pointer;
- the recovery pointer only moves one entry at a time;
- the head lines up with the recovery pointer after a rewind;
- error pulses last one cycle;
- no input or delivery is accepted while recovery holds.

Some properties only the bench scenarios can show. These are the exact output latency, the CRC arithmetic, and whether replay delivers a complete, ordered and duplicate-free sequence. The bench shows them by injecting single-bit corruption and peer errors while flits are streaming, and by comparing every delivered payload against a scoreboard.

// File: rtl/frb_pkg.sv
package frb_pkg;
  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  typedef enum logic [1:0] {
    RS_IDLE   = 2'd0,
    RS_FLUSH  = 2'd1,
    RS_REWIND = 2'd2
  } rec_state_e;

  // CRC over the n least significant bits of d, most significant bit first
  function automatic logic [CRC_W-1:0] crc8_calc(input logic [63:0] d, input int unsigned n);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 63; i >= 0; i--) begin
      if (i < int'(n)) begin
        fb = c[CRC_W-1] ^ d[i];
        c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/frb_mem.sv
module frb_mem #(
  parameter int W     = 24,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/frb_ptrs.sv
module frb_ptrs #(
  parameter int DEPTH = 8,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic          pass,
  input  logic          rewind,
  output logic [PW-1:0] tail_o,
  output logic [PW-1:0] head_o,
  output logic [PW-1:0] rec_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] ONE_P   = PW'(1);

  logic [PW-1:0] tail_q, head_q, rec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q <= '0;
      head_q <= '0;
      rec_q  <= '0;
    end else begin
      if (wr) tail_q <= tail_q + ONE_P;
      if (rewind)  head_q <= rec_q;
      else if (rd) head_q <= head_q + ONE_P;
      if (pass) rec_q <= rec_q + ONE_P;
    end
  end

  // occupancy is measured from the recovery pointer so unconfirmed flits survive
  assign full_o  = (tail_q - rec_q) == DEPTH_P;
  assign empty_o = (head_q == tail_q);
  assign tail_o  = tail_q;
  assign head_o  = head_q;
  assign rec_o   = rec_q;
endmodule

// File: rtl/frb_recover.sv
module frb_recover (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic hold_o,
  output logic rewind_o
);
  import frb_pkg::*;

  rec_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= RS_IDLE;
    end else begin
      unique case (st_q)
        RS_IDLE:   if (trig) st_q <= RS_FLUSH;
        RS_FLUSH:  st_q <= RS_REWIND;
        RS_REWIND: st_q <= RS_IDLE;
        default:   st_q <= RS_IDLE;
      endcase
    end
  end

  assign hold_o   = trig || (st_q != RS_IDLE);
  assign rewind_o = (st_q == RS_REWIND);
endmodule

// File: rtl/frb_out_chk.sv
module frb_out_chk #(
  parameter int DATA_W = 16,
  parameter int CRC_W  = 8,
  parameter int FLIT_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic [FLIT_W-1:0] flit,
  input  logic [FLIT_W-1:0] mask,
  input  logic              hold,
  output logic              pass_o,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              err_o
);
  logic [FLIT_W-1:0] seen;
  logic [CRC_W-1:0]  calc;
  logic              match;

  assign seen   = flit ^ mask;
  assign calc   = frb_pkg::crc8_calc(64'(seen[FLIT_W-1:CRC_W]), DATA_W);
  assign match  = (calc == seen[CRC_W-1:0]);
  assign pass_o = vld && match && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      out_vld_o <= pass_o;
      err_o     <= vld && !match && !hold;
    end
  end

  always_ff @(posedge clk) begin
    out_data_o <= seen[FLIT_W-1:CRC_W];
  end
endmodule

// File: rtl/flit_replay_buf.sv
module flit_replay_buf #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 8,
  parameter int PIPE_LAT = 2,
  localparam int CRC_W   = frb_pkg::CRC_W,
  localparam int FLIT_W  = DATA_W + CRC_W,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld_i,
  input  logic [FLIT_W-1:0] in_flit_i,
  output logic              in_rdy_o,
  input  logic              grant_i,
  input  logic [FLIT_W-1:0] fault_mask_i,
  input  logic              peer_err_i,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              err_o
);
  logic [PW-1:0]     tail_w, head_w, rec_w;
  logic              full_w, empty_w;
  logic              hold_w, rewind_w, pass_w;
  logic              wr_en, rd_en;
  logic [FLIT_W-1:0] mem_q;
  logic [FLIT_W-1:0] sd [PIPE_LAT];
  logic              sv [PIPE_LAT];

  assign in_rdy_o = !full_w && !hold_w;
  assign wr_en    = in_vld_i && in_rdy_o;
  assign rd_en    = grant_i && !empty_w && !hold_w;

  frb_ptrs #(.DEPTH(DEPTH), .PW(PW)) ptrs_i (
    .clk(clk), .rst(rst), .wr(wr_en), .rd(rd_en), .pass(pass_w), .rewind(rewind_w),
    .tail_o(tail_w), .head_o(head_w), .rec_o(rec_w), .full_o(full_w), .empty_o(empty_w)
  );

  frb_mem #(.W(FLIT_W), .DEPTH(DEPTH), .AW(AW)) mem_i (
    .clk(clk), .we(wr_en), .waddr(tail_w[AW-1:0]), .wdata(in_flit_i),
    .re(rd_en), .raddr(head_w[AW-1:0]), .rdata(mem_q)
  );

  frb_recover rec_i (
    .clk(clk), .rst(rst), .trig(err_o || peer_err_i), .hold_o(hold_w), .rewind_o(rewind_w)
  );

  // switch pipeline: stage 0 is the registered buffer read
  for (genvar i = 0; i < PIPE_LAT; i++) begin : g_stage
    logic v_q;
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst || hold_w) v_q <= 1'b0;
        else               v_q <= rd_en;
      end
      assign sd[i] = mem_q;
    end else begin : g_next
      logic [FLIT_W-1:0] d_q;
      always_ff @(posedge clk) begin
        if (rst || hold_w) v_q <= 1'b0;
        else               v_q <= sv[i-1];
      end
      always_ff @(posedge clk) d_q <= sd[i-1];
      assign sd[i] = d_q;
    end
    assign sv[i] = v_q;
  end

  frb_out_chk #(.DATA_W(DATA_W), .CRC_W(CRC_W), .FLIT_W(FLIT_W)) chk_i (
    .clk(clk), .rst(rst), .vld(sv[PIPE_LAT-1]), .flit(sd[PIPE_LAT-1]),
    .mask(fault_mask_i), .hold(hold_w), .pass_o(pass_w),
    .out_vld_o(out_vld_o), .out_data_o(out_data_o), .err_o(err_o)
  );
endmodule

// File: rtl/frb_props.sv
module frb_props #(
  parameter int DEPTH = 8,
  parameter int PW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [PW-1:0] tail,
  input logic [PW-1:0] head,
  input logic [PW-1:0] rec,
  input logic          hold,
  input logic          rewind,
  input logic          in_rdy,
  input logic          out_vld,
  input logic          err
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  // R4
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    (tail - rec) <= DEPTH_P);

  // R10
  rec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rec != $past(rec)) |-> ((rec - $past(rec)) == PW'(1)));

  // R9
  head_order_chk: assert property (@(posedge clk) disable iff (rst)
    (head - rec) <= (tail - rec));

  // R9
  rewind_align_chk: assert property (@(posedge clk) disable iff (rst)
    rewind |=> (head == rec));

  // R8
  hold_blocks_in_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> !in_rdy);

  // R8
  hold_drops_out_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> !out_vld);

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
endmodule

bind flit_replay_buf frb_props #(.DEPTH(DEPTH), .PW(PW)) props_i (
  .clk(clk), .rst(rst), .tail(tail_w), .head(head_w), .rec(rec_w),
  .hold(hold_w), .rewind(rewind_w), .in_rdy(in_rdy_o), .out_vld(out_vld_o), .err(err_o)
);

// File: tb/flit_replay_buf_tb_top.sv
module flit_replay_buf_tb_top;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int LAT    = 2;
  localparam int FLIT_W = DATA_W + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld_i = 1'b0;
  logic [FLIT_W-1:0] in_flit_i = '0;
  logic grant_i = 1'b0;
  logic [FLIT_W-1:0] fault_mask_i = '0;
  logic peer_err_i = 1'b0;
  logic in_rdy_o, out_vld_o, err_o;
  logic [DATA_W-1:0] out_data_o;

  int checks = 0;
  int fails = 0;
  int out_cnt = 0;
  int err_cnt = 0;
  int cyc = 0;
  bit wide_err = 0;
  bit prev_err = 0;
  logic [DATA_W-1:0] exp_q [$];
  logic [DATA_W-1:0] next_id = 16'h0100;

  always #10 clk = ~clk;

  flit_replay_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PIPE_LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .in_vld_i(in_vld_i), .in_flit_i(in_flit_i), .in_rdy_o(in_rdy_o),
    .grant_i(grant_i), .fault_mask_i(fault_mask_i), .peer_err_i(peer_err_i),
    .out_vld_o(out_vld_o), .out_data_o(out_data_o), .err_o(err_o)
  );

  function automatic logic [7:0] tb_crc(input logic [DATA_W-1:0] d);
    logic [7:0] r = 8'h00;
    for (int i = DATA_W - 1; i >= 0; i--)
      r = {r[6:0], 1'b0} ^ (((r[7] ^ d[i]) == 1'b1) ? 8'h07 : 8'h00);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // monitor / scoreboard: R1 R3 R9
  always @(negedge clk) begin
    if (!rst) begin
      if (err_o) err_cnt++;
      if (err_o && prev_err) wide_err = 1;
      prev_err = err_o;
      if (out_vld_o) begin
        out_cnt++;
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected delivery", int'(out_data_o), 0);
        end else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          check(out_data_o == e, "R1 R3 R9 payload order", int'(out_data_o), int'(e));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  // call just after a negedge
  task automatic push_flit();
    logic [DATA_W-1:0] d;
    d = next_id;
    next_id = next_id + 16'h0013;
    in_vld_i = 1'b1;
    in_flit_i = {d, tb_crc(d)};
    #1;
    while (!in_rdy_o) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(d);
    @(negedge clk);
    in_vld_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    int errs0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check(in_rdy_o == 1'b1, "R11 in_rdy", int'(in_rdy_o), 1);
    check(out_vld_o == 1'b0, "R11 out_vld", int'(out_vld_o), 0);
    check(err_o == 1'b0, "R11 err", int'(err_o), 0);

    // R2 latency
    @(negedge clk);
    grant_i = 1'b1;
    in_vld_i = 1'b1;
    in_flit_i = {16'hA5C3, tb_crc(16'hA5C3)};
    exp_q.push_back(16'hA5C3);
    @(negedge clk);
    in_vld_i = 1'b0;
    #1;
    check(out_vld_o == 1'b0, "R2 before edge W+1", int'(out_vld_o), 0);
    @(negedge clk); #1;
    check(out_vld_o == 1'b0, "R2 before edge W+2", int'(out_vld_o), 0);
    @(negedge clk); #1;
    check(out_vld_o == 1'b0, "R2 before edge W+3", int'(out_vld_o), 0);
    @(negedge clk); #1;
    check(out_vld_o == 1'b1, "R2 after edge W+3", int'(out_vld_o), 1);
    idle(4);

    // R4 R5 fill with no grant
    grant_i = 1'b0;
    base = out_cnt;
    for (int k = 0; k < DEPTH; k++) push_flit();
    #1;
    check(in_rdy_o == 1'b0, "R4 full at DEPTH", int'(in_rdy_o), 0);
    idle(10);
    check(out_cnt == base, "R5 no delivery without grant", out_cnt, base);
    // R10 single read, then no confirmation yet
    grant_i = 1'b1;
    @(negedge clk);
    grant_i = 1'b0;
    #1;
    check(in_rdy_o == 1'b0, "R10 read but unconfirmed keeps entry", int'(in_rdy_o), 0);
    idle(5);
    #1;
    check(in_rdy_o == 1'b1, "R10 entry freed after confirmation", int'(in_rdy_o), 1);
    grant_i = 1'b1;
    idle(30);
    check(exp_q.size() == 0, "R3 drain after fill", exp_q.size(), 0);

    // R6 R9 streaming with single-bit corruption
    errs0 = err_cnt;
    fork
      for (int k = 0; k < 24; k++) push_flit();
      begin
        idle(6);
        fault_mask_i = 24'h000008;
        @(negedge clk);
        fault_mask_i = '0;
        idle(9);
        fault_mask_i = 24'h010000;
        @(negedge clk);
        fault_mask_i = '0;
      end
    join
    idle(40);
    check(err_cnt > errs0, "R6 corruption reported", err_cnt - errs0, 1);
    check(exp_q.size() == 0, "R3 R9 complete after replay", exp_q.size(), 0);

    // R8 hold window on peer error
    @(negedge clk);
    peer_err_i = 1'b1;
    #1;
    check(in_rdy_o == 1'b0, "R8 hold in error cycle", int'(in_rdy_o), 0);
    @(negedge clk);
    peer_err_i = 1'b0;
    #1;
    check(in_rdy_o == 1'b0, "R8 hold in flush cycle", int'(in_rdy_o), 0);
    @(negedge clk); #1;
    check(in_rdy_o == 1'b0, "R8 hold in rewind cycle", int'(in_rdy_o), 0);
    @(negedge clk); #1;
    check(in_rdy_o == 1'b1, "R8 released after rewind", int'(in_rdy_o), 1);

    // R7 peer errors while streaming
    fork
      for (int k = 0; k < 16; k++) push_flit();
      begin
        idle(7);
        peer_err_i = 1'b1;
        @(negedge clk);
        peer_err_i = 1'b0;
        idle(5);
        peer_err_i = 1'b1;
        @(negedge clk);
        peer_err_i = 1'b0;
      end
    join
    idle(40);
    check(exp_q.size() == 0, "R7 complete after peer replay", exp_q.size(), 0);
    check(!wide_err, "R6 err pulse one cycle", int'(wide_err), 0);
    summary();
  end
endmodule